// File: doc/BRIEF.md
# Test Access Port Controller with Shared Reset / Debug-Event Pin

This block is a serial test access port controller that works in the system clock domain. The test clock, mode-select and data inputs are sampled by the system clock. A registered copy of the test clock marks its rising and falling edges. On each rising edge the sixteen-state controller advances according to the mode-select input. The controller owns a 4-bit instruction register and a 1-bit bypass register. The serial output and its enable update only on falling edges, so the output is valid for the whole next rising edge.

A single board pin has two roles, selected by two control bits. The pin can be an active-low reset input for the controller. It can instead be an open-drain output that the block pulls low when a debug event occurs. There is also a quiet mode in which the pin is left to its pull-up. The pin is modelled as a sampled level input plus a drive-low enable. An outside model supplies the pull-up and any external driver. A debug event is any of these:
- a hardware breakpoint;
- a software breakpoint;
- a trace hit;
- loading the debug-request instruction at Update-IR.

Each event is latched until the debug logic acknowledges it.

Top module: `tap_evt_pin`

## Requirements
- R1: On every TCK rising edge the controller moves to the next state selected by TMS, following the standard sixteen-state graph. `tap_state` reports the state with this 4-bit encoding: Test-Logic-Reset F, Run-Test/Idle C, Select-DR 7, Capture-DR 6, Shift-DR 2, Exit1-DR 1, Pause-DR 3, Exit2-DR 0, Update-DR 5, Select-IR 4, Capture-IR E, Shift-IR A, Exit1-IR 9, Pause-IR B, Exit2-IR 8, Update-IR D.
- R2: Five TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state. While it stays in Test-Logic-Reset, the instruction register holds the all-ones code.
- R3: Leaving Capture-IR loads 0001 into the instruction shift stage. Each rising edge in Shift-IR shifts it one place toward TDO, least significant bit first, with TDI entering the top bit. Leaving Update-IR copies the shift stage into the instruction register.
- R4: Every data-register scan goes through the 1-bit bypass stage. That stage captures 0 when leaving Capture-DR and takes TDI on each rising edge in Shift-DR.
- R5: `tdo` and `tdo_oe` change only on TCK falling edges. `tdo_oe` becomes 1 only when the controller is in Shift-IR or Shift-DR. `tdo` reads 0 whenever `tdo_oe` is 0.
- R6: `dbg_req` is 1 while the instruction register holds 0111. Loading 0111 at Update-IR is a debug event.
- R7: When `cfg_evt_en` is 0, the pin is never driven. A low level on `pin_in` forces Test-Logic-Reset at the next clock, whatever the value of `cfg_evt_quiet`.
- R8: When `cfg_evt_en` is 1 and `cfg_evt_quiet` is 0, a debug event latches `pin_drive_low` high. It stays high until `evt_ack`. An event in the same cycle as `evt_ack` wins. A low pin in this mode does not reset the controller.
- R9: When `cfg_evt_en` and `cfg_evt_quiet` are both 1, the pin is never driven. Events in this mode are not stored. A low pin does not reset the controller.
- R10: A synchronous `rst` puts the controller in Test-Logic-Reset, the instruction register at all ones, `tdo_oe` and `tdo` at 0, and `pin_drive_low` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Test clock, sampled by clk |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for tdo (tri-state control) |
| tap_state | output | 4 | Current controller state, encoded as in R1 |
| dbg_req | output | 1 | Instruction register holds the debug-request code |
| cfg_evt_en | input | 1 | Pin mode bit: 0 reset input, 1 event output |
| cfg_evt_quiet | input | 1 | Pin mode bit: suppresses event drive when set |
| pin_in | input | 1 | Sampled level of the shared pin |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the shared pin |
| hw_break | input | 1 | Hardware breakpoint event |
| sw_break | input | 1 | Software breakpoint event |
| trace_hit | input | 1 | Trace event |
| evt_ack | input | 1 | Clears a latched debug event |

## Verification
The assertions assume that TCK, TMS and TDI are synchronous to clk, or held steady around its edges. They also assume that each TCK phase lasts several clk cycles, so that one rising and one falling edge never share a cycle. The bench holds each TCK phase for four clk periods, which gives eight clk cycles per TCK period. It changes TMS and TDI only together with the TCK rise, on clk falling edges. The control bits and event inputs are also changed on clk falling edges. The pin level is derived from the drive enable and a bench-side external pull-down, in the way a pull-up resistor would behave.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        S_EX2_DR  = 4'h0,
        S_EX1_DR  = 4'h1,
        S_SH_DR   = 4'h2,
        S_PAU_DR  = 4'h3,
        S_SEL_IR  = 4'h4,
        S_UPD_DR  = 4'h5,
        S_CAP_DR  = 4'h6,
        S_SEL_DR  = 4'h7,
        S_EX2_IR  = 4'h8,
        S_EX1_IR  = 4'h9,
        S_SH_IR   = 4'hA,
        S_PAU_IR  = 4'hB,
        S_IDLE    = 4'hC,
        S_UPD_IR  = 4'hD,
        S_CAP_IR  = 4'hE,
        S_TLR     = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {
        PIN_RST_IN  = 2'd0,
        PIN_EVT_OUT = 2'd1,
        PIN_QUIET   = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic tms;
        logic tdi;
    } tck_evt_t;

    localparam int          IR_W_DEF     = 4;
    localparam logic [3:0]  IR_CAP_DEF   = 4'b0001;
    localparam logic [3:0]  IR_DBG_DEF   = 4'b0111;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            S_TLR:    n = m ? S_TLR    : S_IDLE;
            S_IDLE:   n = m ? S_SEL_DR : S_IDLE;
            S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: n = m ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  n = m ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: n = m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: n = m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: n = m ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: n = m ? S_SEL_DR : S_IDLE;
            S_SEL_IR: n = m ? S_TLR    : S_CAP_IR;
            S_CAP_IR: n = m ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  n = m ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: n = m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: n = m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: n = m ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: n = m ? S_SEL_DR : S_IDLE;
            default:  n = S_TLR;
        endcase
        return n;
    endfunction

    function automatic pin_mode_e pin_mode_of(input logic en, input logic quiet);
        if (!en)
            return PIN_RST_IN;
        return quiet ? PIN_QUIET : PIN_EVT_OUT;
    endfunction

endpackage

// File: rtl/tap_tck_edge.sv
module tap_tck_edge
    import tap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tck,
    input  logic     tms,
    input  logic     tdi,
    output tck_evt_t ev
);
    logic tck_q;

    always_ff @(posedge clk) begin
        if (rst)
            tck_q <= 1'b0;
        else
            tck_q <= tck;
    end

    always_comb begin
        ev.rise = tck & ~tck_q;
        ev.fall = ~tck & tck_q;
        ev.tms  = tms;
        ev.tdi  = tdi;
    end
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_rst,
    input  logic       rise,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge clk) begin
        if (rst || pin_rst)
            state <= S_TLR;
        else if (rise)
            state <= tap_next(state, tms);
    end

    // R7: a pin reset in input mode lands in Test-Logic-Reset
    a_r7_pin_reset: assert property (@(posedge clk) disable iff (rst)
        pin_rst |=> state == S_TLR);

    // R2: TMS high keeps the controller parked in Test-Logic-Reset
    a_r2_tlr_hold: assert property (@(posedge clk) disable iff (rst)
        (state == S_TLR && rise && tms) |=> state == S_TLR);

    // R1: the state only moves on a TCK rise or a reset
    a_r1_move_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(state) |-> ($past(rise) || $past(pin_rst)));
endmodule

// File: rtl/tap_shift.sv
module tap_shift
    import tap_pkg::*;
#(
    parameter int                IR_W     = IR_W_DEF,
    parameter logic [IR_W-1:0]   CAP_CODE = IR_CAP_DEF,
    parameter logic [IR_W-1:0]   DBG_CODE = IR_DBG_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       fall,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       tdo,
    output logic       tdo_oe,
    output logic       dbg_req,
    output logic       dbg_evt
);
    localparam logic [IR_W-1:0] BYP_CODE = '1;

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;
    logic            byp_q;
    logic            in_shift;

    assign in_shift = (state == S_SH_IR) || (state == S_SH_DR);

    always_ff @(posedge clk) begin
        if (rst || state == S_TLR) begin
            ir_q    <= BYP_CODE;
            ir_sh   <= '0;
            byp_q   <= 1'b0;
            dbg_evt <= 1'b0;
        end else begin
            dbg_evt <= 1'b0;
            if (rise) begin
                case (state)
                    S_CAP_IR: ir_sh <= CAP_CODE;
                    S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                    S_UPD_IR: begin
                        ir_q    <= ir_sh;
                        dbg_evt <= (ir_sh == DBG_CODE);
                    end
                    S_CAP_DR: byp_q <= 1'b0;
                    S_SH_DR:  byp_q <= tdi;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (fall) begin
            tdo_oe <= in_shift;
            if (state == S_SH_IR)
                tdo <= ir_sh[0];
            else if (state == S_SH_DR)
                tdo <= byp_q;
            else
                tdo <= 1'b0;
        end
    end

    assign dbg_req = (ir_q == DBG_CODE);

    // R5: output pins only change on a TCK fall
    a_r5_fall_only: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tdo) || !$stable(tdo_oe)) |-> $past(fall));

    // R5: enable only turns on from a shift state
    a_r5_oe_shift: assert property (@(posedge clk) disable iff (rst)
        $rose(tdo_oe) |-> ($past(state) == S_SH_IR || $past(state) == S_SH_DR));

    // R5: disabled output reads zero
    a_r5_tdo_quiet: assert property (@(posedge clk) disable iff (rst)
        !tdo_oe |-> !tdo);
endmodule

// File: rtl/tap_evt_pin_ctl.sv
module tap_evt_pin_ctl
    import tap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    input  logic cfg_quiet,
    input  logic pin_in,
    input  logic hw_break,
    input  logic sw_break,
    input  logic trace_hit,
    input  logic dbg_evt,
    input  logic evt_ack,
    output logic pin_rst,
    output logic drive_low
);
    pin_mode_e mode;
    logic      any_evt;
    logic      evt_flag;

    assign mode    = pin_mode_of(cfg_en, cfg_quiet);
    assign any_evt = hw_break | sw_break | trace_hit | dbg_evt;

    always_ff @(posedge clk) begin
        if (rst || mode != PIN_EVT_OUT)
            evt_flag <= 1'b0;
        else if (any_evt)
            evt_flag <= 1'b1;
        else if (evt_ack)
            evt_flag <= 1'b0;
    end

    assign drive_low = evt_flag && (mode == PIN_EVT_OUT);
    assign pin_rst   = (mode == PIN_RST_IN) && !pin_in;

    // R8: pin is pulled low only after a debug event
    a_r8_drive_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> $past(any_evt));

    // R8: acknowledge with no new event releases the pin
    a_r8_ack_release: assert property (@(posedge clk) disable iff (rst)
        (drive_low && evt_ack && !any_evt) |=> !drive_low);
endmodule

// File: rtl/tap_evt_pin.sv
module tap_evt_pin
    import tap_pkg::*;
#(
    parameter int              IR_W     = IR_W_DEF,
    parameter logic [IR_W-1:0] CAP_CODE = IR_CAP_DEF,
    parameter logic [IR_W-1:0] DBG_CODE = IR_DBG_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tck,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic       tdo_oe,
    output logic [3:0] tap_state,
    output logic       dbg_req,
    input  logic       cfg_evt_en,
    input  logic       cfg_evt_quiet,
    input  logic       pin_in,
    output logic       pin_drive_low,
    input  logic       hw_break,
    input  logic       sw_break,
    input  logic       trace_hit,
    input  logic       evt_ack
);
    tck_evt_t   ev;
    tap_state_e state;
    logic       pin_rst;
    logic       dbg_evt;

    tap_tck_edge u_edge (
        .clk (clk),
        .rst (rst),
        .tck (tck),
        .tms (tms),
        .tdi (tdi),
        .ev  (ev)
    );

    tap_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pin_rst (pin_rst),
        .rise    (ev.rise),
        .tms     (ev.tms),
        .state   (state)
    );

    tap_shift #(
        .IR_W     (IR_W),
        .CAP_CODE (CAP_CODE),
        .DBG_CODE (DBG_CODE)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .rise    (ev.rise),
        .fall    (ev.fall),
        .tdi     (ev.tdi),
        .state   (state),
        .tdo     (tdo),
        .tdo_oe  (tdo_oe),
        .dbg_req (dbg_req),
        .dbg_evt (dbg_evt)
    );

    tap_evt_pin_ctl u_pin (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_evt_en),
        .cfg_quiet (cfg_evt_quiet),
        .pin_in    (pin_in),
        .hw_break  (hw_break),
        .sw_break  (sw_break),
        .trace_hit (trace_hit),
        .dbg_evt   (dbg_evt),
        .evt_ack   (evt_ack),
        .pin_rst   (pin_rst),
        .drive_low (pin_drive_low)
    );

    assign tap_state = state;
endmodule

// File: tb/sim_tap_evt_pin.sv
`timescale 1ns/1ps
module sim_tap_evt_pin;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic de = 1'b1, drm = 1'b1, ext_low = 1'b0;
    logic hw = 1'b0, sw = 1'b0, tr = 1'b0, ack = 1'b0;
    logic tdo, tdo_oe, dbg_req, drive_low;
    logic [3:0] st;
    logic pin_level;
    int n_cmp = 0, n_bad = 0;

    assign pin_level = !(drive_low || ext_low);

    always #2.5 clk = ~clk;

    tap_evt_pin u0 (
        .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(st), .dbg_req(dbg_req),
        .cfg_evt_en(de), .cfg_evt_quiet(drm), .pin_in(pin_level),
        .pin_drive_low(drive_low), .hw_break(hw), .sw_break(sw),
        .trace_hit(tr), .evt_ack(ack)
    );

    // fields: tms, tdi, state[3:0], oe, tdo, dbg_req
    localparam logic [8:0] VEC [37] = '{
        9'b0_0_1100_0_0_0, 9'b1_0_0111_0_0_0, 9'b1_0_0100_0_0_0, 9'b0_0_1110_0_0_0,
        9'b0_0_1010_1_1_0, 9'b0_1_1010_1_0_0, 9'b0_1_1010_1_0_0, 9'b0_1_1010_1_0_0,
        9'b1_0_1001_0_0_0, 9'b1_0_1101_0_0_0, 9'b0_0_1100_0_0_1, 9'b1_0_0111_0_0_1,
        9'b0_0_0110_0_0_1, 9'b0_1_0010_1_0_1, 9'b0_1_0010_1_1_1, 9'b0_0_0010_1_0_1,
        9'b1_1_0001_0_0_1, 9'b0_0_0011_0_0_1, 9'b1_0_0000_0_0_1, 9'b1_0_0101_0_0_1,
        9'b1_0_0111_0_0_1, 9'b1_0_0100_0_0_1, 9'b1_0_1111_0_0_0, 9'b0_0_1100_0_0_0,
        9'b1_0_0111_0_0_0, 9'b1_0_0100_0_0_0, 9'b0_0_1110_0_0_0, 9'b0_0_1010_1_1_0,
        9'b1_0_1001_0_0_0, 9'b0_0_1011_0_0_0, 9'b1_0_1000_0_0_0, 9'b0_0_1010_1_0_0,
        9'b1_0_1001_0_0_0, 9'b1_0_1101_0_0_0, 9'b1_0_0111_0_0_0, 9'b1_0_0100_0_0_0,
        9'b1_0_1111_0_0_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tck_cyc(input logic m, input logic d);
        @(negedge clk);
        tms = m; tdi = d; tck = 1'b1;
        repeat (4) @(negedge clk);
        tck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic h, input logic s, input logic t, input logic a);
        @(negedge clk);
        hw = h; sw = s; tr = t; ack = a;
        @(negedge clk);
        hw = 1'b0; sw = 1'b0; tr = 1'b0; ack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_ir(input logic [3:0] code);
        tck_cyc(1'b0, 1'b0); tck_cyc(1'b1, 1'b0); tck_cyc(1'b1, 1'b0);
        tck_cyc(1'b0, 1'b0); tck_cyc(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) tck_cyc(i == 3, code[i]);
        tck_cyc(1'b1, 1'b0); tck_cyc(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset state", st, 4'hF);
        chk("R10 reset oe", tdo_oe, 0);
        chk("R10 reset tdo", tdo, 0);
        chk("R10 reset drive", drive_low, 0);
        chk("R10 reset dbg_req", dbg_req, 0);

        // vector walk, quiet pin mode
        for (int i = 0; i < 37; i++) begin
            tck_cyc(VEC[i][8], VEC[i][7]);
            chk($sformatf("R1 row %0d state", i), st, VEC[i][6:3]);
            chk($sformatf("R5 row %0d oe", i), tdo_oe, VEC[i][2]);
            chk($sformatf("R3 R4 row %0d tdo", i), tdo, VEC[i][1]);
            chk($sformatf("R6 row %0d dbg_req", i), dbg_req, VEC[i][0]);
            chk($sformatf("R9 row %0d drive", i), drive_low, 0);
        end

        // R2: five TMS-high edges from Shift-DR
        tck_cyc(0, 0); tck_cyc(1, 0); tck_cyc(0, 0); tck_cyc(0, 0);
        chk("R2 at shift-dr", st, 4'h2);
        for (int i = 0; i < 4; i++) tck_cyc(1, 0);
        chk("R2 after four", st, 4'h4);
        tck_cyc(1, 0);
        chk("R2 after five", st, 4'hF);

        // R7: input mode pin reset, quiet bit ignored
        de = 1'b0; drm = 1'b1;
        tck_cyc(0, 0); tck_cyc(1, 0); tck_cyc(0, 0); tck_cyc(0, 0);
        chk("R7 pre-reset state", st, 4'h2);
        @(negedge clk); ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 pin reset drm1", st, 4'hF);
        ext_low = 1'b0;
        pulse(1, 0, 0, 0);
        chk("R7 no drive in input mode", drive_low, 0);
        drm = 1'b0;
        tck_cyc(0, 0);
        chk("R7 idle before reset", st, 4'hC);
        @(negedge clk); ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 pin reset drm0", st, 4'hF);
        ext_low = 1'b0;

        // R9: quiet output mode
        de = 1'b1; drm = 1'b1;
        tck_cyc(0, 0);
        @(negedge clk); ext_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 low pin no reset", st, 4'hC);
        ext_low = 1'b0;
        pulse(1, 0, 0, 0);
        chk("R9 event not driven", drive_low, 0);
        drm = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 event not stored", drive_low, 0);

        // R8: event output mode
        pulse(1, 0, 0, 0);
        chk("R8 hw event drives", drive_low, 1);
        chk("R8 driven pin no reset", st, 4'hC);
        pulse(0, 0, 0, 1);
        chk("R8 ack releases", drive_low, 0);
        pulse(0, 1, 0, 0);
        chk("R8 sw event drives", drive_low, 1);
        pulse(0, 0, 0, 1);
        chk("R8 ack after sw", drive_low, 0);
        pulse(0, 0, 1, 0);
        chk("R8 trace event drives", drive_low, 1);
        pulse(0, 0, 0, 1);
        chk("R8 ack after trace", drive_low, 0);
        pulse(1, 0, 0, 1);
        chk("R8 event beats ack", drive_low, 1);
        pulse(0, 0, 0, 1);
        chk("R8 ack after tie", drive_low, 0);

        // R6: debug-request instruction as event
        for (int i = 0; i < 5; i++) tck_cyc(1, 0);
        load_ir(4'b0111);
        chk("R6 dbg_req after load", dbg_req, 1);
        chk("R6 R8 dbg load drives pin", drive_low, 1);
        pulse(0, 0, 0, 1);
        chk("R8 ack after dbg", drive_low, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule